// File: doc/BRIEF.md
# Filtered Event Counter Bank for an I/O Translation Unit

This block holds a small bank of 64-bit performance counters for an I/O address-translation unit. Each counter has its own selector register and its own inhibit bit. The selector names one event code and can optionally narrow counting to particular requesters.

The translation logic presents each countable occurrence as a single-cycle pulse. The pulse carries an event code and the context of the transaction: device identifier, process identifier with its valid flag, guest soft-context identifier and process soft-context identifier.

Each counter decides on its own whether the pulse counts. Three things must hold:
- the codes must agree;
- an optional process filter must pass;
- an optional device filter must pass. This filter can compare exactly, or over a naturally aligned block of identifiers encoded in the programmed value itself.

A counter that passes all of these at the all-ones value wraps to zero. It then records a sticky overflow in the summary register. If that overflow is new, it also sets the selector's overflow flag and pulses the interrupt line.

Software reaches every register through a flat read/write port. Reads are combinational. Writes are single-cycle strobes.

Top module: `hpm_event_bank`

## Requirements
- R1: Counter n owns bit n+1 of the inhibit register (address 0) and of the overflow summary register (address 1); bit 0 and bits above NUM_CTRS of both always read zero, and the summary register ignores writes.
- R2: A counter whose inhibit bit is 1 keeps its value whatever events arrive.
- R3: A counter increments by one only when an event pulse carries exactly the code held in selector bits [14:0]; a stored code of 0 never matches.
- R4: Selector bit 62 picks the filter sources: 1 compares against the guest context identifier (zero-extended to 24 bits) and the process context identifier; 0 compares against the device identifier and the process identifier.
- R5: With selector bit 60 set, an event whose process-valid flag is 1 counts only if its process source equals selector bits [35:16]; an event with the flag at 0 passes this filter.
- R6: With selector bit 61 set, the device source must equal selector bits [59:36]. With bit 15 also set, the bits at and below the lowest zero bit of the programmed value are excluded from the compare (an all-ones value matches any source).
- R7: A counting event at the all-ones value wraps the counter to zero and sets its summary bit. Only when that summary bit was 0 beforehand does the selector's bit 63 get set and pm_irq go high, for exactly the one cycle after that edge.
- R8: Writing a selector with bit 63 at 0 while its summary bit is 1 clears the summary bit.
- R9: A selector write whose code field is 0 or at least NUM_EVENTS stores code 0; every other selector bit is stored as written.
- R10: Counter n's value is at address 32+n and its selector at address 64+n. Writes to an index at or above NUM_CTRS, or to any other unused address, change nothing, and such addresses read zero.
- R11: In a cycle where software writes counter n's value or selector, counter n ignores an event, so the written value is what is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | One-cycle event pulse |
| evt_id | input | 15 | Event code |
| evt_dev_id | input | 24 | Transaction device identifier |
| evt_pid | input | 20 | Transaction process identifier |
| evt_pid_valid | input | 1 | Process identifier present |
| evt_gscid | input | 16 | Guest soft-context identifier |
| evt_pscid | input | 20 | Process soft-context identifier |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 7 | Write address |
| reg_wr_data | input | 64 | Write data |
| reg_rd_addr | input | 7 | Read address |
| reg_rd_data | output | 64 | Read data, combinational |
| pm_irq | output | 1 | Overflow interrupt pulse |

## Verification
An event or write presented before clock edge k changes counters, selectors and the summary at edge k. The read port shows the new state in the same cycle, because it is combinational. pm_irq is registered, so it is high for exactly the cycle following edge k.

The bench drives every stimulus on a falling edge and waits through one rising edge. On the next falling edge it first compares pm_irq with the model's prediction, then walks the read port. Each comparison is therefore made in the single cycle where its result is due. A stale or early interrupt shows up as a mismatch in the neighbouring cycle.

// File: rtl/hpm_bank_pkg.sv
package hpm_bank_pkg;

  localparam int EVID_W  = 15;
  localparam int PID_W   = 20;
  localparam int DID_W   = 24;
  localparam int GSCID_W = 16;
  localparam int REG_W   = 64;

  // Transaction context of one event pulse.
  typedef struct packed {
    logic [EVID_W-1:0]  id;
    logic [DID_W-1:0]   dev_id;
    logic [PID_W-1:0]   pid;
    logic               pid_valid;
    logic [GSCID_W-1:0] gscid;
    logic [PID_W-1:0]   pscid;
  } hpm_evt_t;

  // Selector register, bit 63 first.
  typedef struct packed {
    logic              of;     // 63
    logic              idt;    // 62
    logic              dv;     // 61
    logic              pv;     // 60
    logic [DID_W-1:0]  did;    // 59:36
    logic [PID_W-1:0]  pidf;   // 35:16
    logic              dmask;  // 15
    logic [EVID_W-1:0] evid;   // 14:0
  } hpm_sel_t;

  // Compare mask for an aligned identifier block: clears bits up to and
  // including the lowest zero of the programmed value.
  function automatic logic [DID_W-1:0] did_block_mask(input logic [DID_W-1:0] v);
    did_block_mask = ~(v ^ (v + 1'b1));
  endfunction

  // Legalise a code field: out-of-range codes collapse to zero.
  function automatic logic [EVID_W-1:0] legal_code(input logic [EVID_W-1:0] c,
                                                   input int unsigned n_events);
    if (c == '0 || 32'(c) >= n_events) legal_code = '0;
    else legal_code = c;
  endfunction

endpackage

// File: rtl/hpm_evt_filter.sv
module hpm_evt_filter
  import hpm_bank_pkg::*;
(
  input  hpm_sel_t sel,
  input  hpm_evt_t evt,
  output logic     id_ok,
  output logic     pid_ok,
  output logic     did_ok,
  output logic     match
);

  logic [DID_W-1:0] dev_src;
  logic [PID_W-1:0] proc_src;
  logic [DID_W-1:0] cmp_mask;

  always_comb begin
    dev_src  = sel.idt ? {{(DID_W-GSCID_W){1'b0}}, evt.gscid} : evt.dev_id;
    proc_src = sel.idt ? evt.pscid : evt.pid;
    cmp_mask = sel.dmask ? did_block_mask(sel.did) : '1;
    id_ok    = (sel.evid != '0) && (sel.evid == evt.id);
    pid_ok   = !sel.pv || !evt.pid_valid || (sel.pidf == proc_src);
    did_ok   = !sel.dv || ((sel.did & cmp_mask) == (dev_src & cmp_mask));
    match    = id_ok && pid_ok && did_ok;
  end

endmodule

// File: rtl/hpm_counter_slice.sv
module hpm_counter_slice
  import hpm_bank_pkg::*;
#(
  parameter int CTR_W      = 64,
  parameter int NUM_EVENTS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  input  hpm_evt_t         evt,
  input  logic             inhibit,
  input  logic             wr_ctr,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             sum_bit,
  output logic [CTR_W-1:0] ctr_q,
  output hpm_sel_t         sel_q,
  output logic             wrap_o,
  output logic             fresh_ovf_o,
  output logic             sum_clr_o
);

  logic     id_ok, pid_ok, did_ok, filt_match;
  logic     hit, bump;
  hpm_sel_t sel_wr;

  hpm_evt_filter u_filt (
    .sel   (sel_q),
    .evt   (evt),
    .id_ok (id_ok),
    .pid_ok(pid_ok),
    .did_ok(did_ok),
    .match (filt_match)
  );

  always_comb begin
    hit         = evt_valid && !inhibit && filt_match;
    bump        = hit && !wr_ctr && !wr_sel;
    wrap_o      = bump && (ctr_q == '1);
    fresh_ovf_o = wrap_o && !sum_bit;
    sum_clr_o   = wr_sel && !wr_data[REG_W-1] && sum_bit;
    sel_wr      = hpm_sel_t'(wr_data);
    sel_wr.evid = legal_code(sel_wr.evid, NUM_EVENTS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctr_q <= '0;
    end else if (wr_ctr) begin
      ctr_q <= wr_data[CTR_W-1:0];
    end else if (bump) begin
      ctr_q <= ctr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (wr_sel) begin
      sel_q <= sel_wr;
    end else if (fresh_ovf_o) begin
      sel_q.of <= 1'b1;
    end
  end

  AST_INHIBIT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit && !wr_ctr |=> $stable(ctr_q)); // R2
  AST_INVALID_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q.evid == '0) |-> !id_ok); // R3
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (ctr_q == '0)); // R7
  AST_FRESH_SETS_OF: assert property (@(posedge clk) disable iff (!rst_n)
    fresh_ovf_o |=> sel_q.of); // R7
  AST_SEL_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sel_q.evid) < NUM_EVENTS); // R9
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctr |=> (ctr_q == $past(wr_data[CTR_W-1:0]))); // R11

endmodule

// File: rtl/hpm_event_bank.sv
module hpm_event_bank
  import hpm_bank_pkg::*;
#(
  parameter int NUM_CTRS   = 4,
  parameter int NUM_EVENTS = 16,
  parameter int CTR_W      = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        evt_valid,
  input  logic [14:0] evt_id,
  input  logic [23:0] evt_dev_id,
  input  logic [19:0] evt_pid,
  input  logic        evt_pid_valid,
  input  logic [15:0] evt_gscid,
  input  logic [19:0] evt_pscid,
  input  logic        reg_wr_en,
  input  logic [6:0]  reg_wr_addr,
  input  logic [63:0] reg_wr_data,
  input  logic [6:0]  reg_rd_addr,
  output logic [63:0] reg_rd_data,
  output logic        pm_irq
);

  localparam int IDX_W       = 5;
  localparam int ADDR_W      = IDX_W + 2;
  localparam logic [1:0] RGN_CTL = 2'd0;
  localparam logic [1:0] RGN_CTR = 2'd1;
  localparam logic [1:0] RGN_SEL = 2'd2;
  localparam logic [IDX_W-1:0] IDX_INH = 5'd0;
  localparam logic [IDX_W-1:0] IDX_OVF = 5'd1;

  hpm_evt_t evt;
  logic [1:0]       wr_rgn, rd_rgn;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  logic [NUM_CTRS:1]   inh_q;
  logic [NUM_CTRS:1]   ovf_q;
  logic                irq_q;

  logic [CTR_W-1:0]    ctr_arr [NUM_CTRS];
  hpm_sel_t            sel_arr [NUM_CTRS];
  logic [NUM_CTRS-1:0] wr_ctr, wr_sel, wrap, fresh, sum_clr;

  always_comb begin
    evt.id        = evt_id;
    evt.dev_id    = evt_dev_id;
    evt.pid       = evt_pid;
    evt.pid_valid = evt_pid_valid;
    evt.gscid     = evt_gscid;
    evt.pscid     = evt_pscid;
    wr_rgn        = reg_wr_addr[ADDR_W-1:IDX_W];
    wr_idx        = reg_wr_addr[IDX_W-1:0];
    rd_rgn        = reg_rd_addr[ADDR_W-1:IDX_W];
    rd_idx        = reg_rd_addr[IDX_W-1:0];
  end

  for (genvar g = 0; g < NUM_CTRS; g++) begin : g_slice
    assign wr_ctr[g] = reg_wr_en && (wr_rgn == RGN_CTR) && (wr_idx == IDX_W'(g));
    assign wr_sel[g] = reg_wr_en && (wr_rgn == RGN_SEL) && (wr_idx == IDX_W'(g));

    hpm_counter_slice #(
      .CTR_W     (CTR_W),
      .NUM_EVENTS(NUM_EVENTS)
    ) u_slice (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_valid  (evt_valid),
      .evt        (evt),
      .inhibit    (inh_q[g+1]),
      .wr_ctr     (wr_ctr[g]),
      .wr_sel     (wr_sel[g]),
      .wr_data    (reg_wr_data),
      .sum_bit    (ovf_q[g+1]),
      .ctr_q      (ctr_arr[g]),
      .sel_q      (sel_arr[g]),
      .wrap_o     (wrap[g]),
      .fresh_ovf_o(fresh[g]),
      .sum_clr_o  (sum_clr[g])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ovf_q[g+1] <= 1'b0;
      end else if (wrap[g]) begin
        ovf_q[g+1] <= 1'b1;
      end else if (sum_clr[g]) begin
        ovf_q[g+1] <= 1'b0;
      end
    end

    AST_SUMMARY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      wrap[g] |=> ovf_q[g+1]); // R7
    AST_SUMMARY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q[g+1] && !sum_clr[g] |=> ovf_q[g+1]); // R8
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inh_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (reg_wr_en && (wr_rgn == RGN_CTL) && (wr_idx == IDX_INH)) begin
        inh_q <= reg_wr_data[NUM_CTRS:1];
      end
      irq_q <= |fresh;
    end
  end

  assign pm_irq = irq_q;

  always_comb begin
    reg_rd_data = '0;
    unique case (rd_rgn)
      RGN_CTL: begin
        if (rd_idx == IDX_INH) reg_rd_data[NUM_CTRS:1] = inh_q;
        else if (rd_idx == IDX_OVF) reg_rd_data[NUM_CTRS:1] = ovf_q;
      end
      RGN_CTR: begin
        for (int n = 0; n < NUM_CTRS; n++) begin
          if (rd_idx == IDX_W'(n)) reg_rd_data[CTR_W-1:0] = ctr_arr[n];
        end
      end
      RGN_SEL: begin
        for (int n = 0; n < NUM_CTRS; n++) begin
          if (rd_idx == IDX_W'(n)) reg_rd_data = sel_arr[n];
        end
      end
      default: reg_rd_data = '0;
    endcase
  end

  AST_IRQ_NEEDS_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    pm_irq |-> (ovf_q != '0)); // R7
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pm_irq && (fresh == '0) |=> !pm_irq); // R7
  AST_PARAM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (NUM_CTRS >= 1) && (NUM_CTRS <= 31) && (CTR_W <= REG_W) |-> 1'b1 ##0 reg_rd_data[0] == 1'b0 || rd_rgn != RGN_CTL); // R1

endmodule

// File: tb/sim_hpm_event_bank.sv
module sim_hpm_event_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NE = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [14:0] evt_id = '0;
  logic [23:0] evt_dev_id = '0;
  logic [19:0] evt_pid = '0;
  logic        evt_pid_valid = 1'b0;
  logic [15:0] evt_gscid = '0;
  logic [19:0] evt_pscid = '0;
  logic        reg_wr_en = 1'b0;
  logic [6:0]  reg_wr_addr = '0;
  logic [63:0] reg_wr_data = '0;
  logic [6:0]  reg_rd_addr = '0;
  logic [63:0] reg_rd_data;
  logic        pm_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  bit [63:0] m_ctr [NC];
  bit [63:0] m_sel [NC];
  bit [NC:1] m_inh;
  bit [NC:1] m_ovf;
  bit        m_irq;

  hpm_event_bank #(.NUM_CTRS(NC), .NUM_EVENTS(NE), .CTR_W(64)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_id(evt_id),
    .evt_dev_id(evt_dev_id), .evt_pid(evt_pid), .evt_pid_valid(evt_pid_valid),
    .evt_gscid(evt_gscid), .evt_pscid(evt_pscid), .reg_wr_en(reg_wr_en),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data), .pm_irq(pm_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit [63:0] sel_word(bit [14:0] code, bit dmask, bit [19:0] pf,
                                         bit [23:0] df, bit pv, bit dv, bit idt);
    bit [63:0] w = '0;
    w[14:0] = code; w[15] = dmask; w[35:16] = pf; w[59:36] = df;
    w[60] = pv; w[61] = dv; w[62] = idt;
    return w;
  endfunction

  // Model of the filters, written from the requirements.
  function automatic bit m_hit(bit [63:0] s, bit [14:0] id, bit [23:0] dev,
                               bit [19:0] pid, bit pv, bit [15:0] gs, bit [19:0] ps);
    bit [23:0] dsrc, prog, msk;
    bit [19:0] psrc;
    int low;
    if (s[14:0] == 0 || s[14:0] != id) return 0;                // R3
    dsrc = s[62] ? {8'h00, gs} : dev;                            // R4
    psrc = s[62] ? ps : pid;
    if (s[60] && pv && s[35:16] != psrc) return 0;               // R5
    if (s[61]) begin                                             // R6
      prog = s[59:36];
      msk = '1;
      if (s[15]) begin
        low = 24;
        for (int i = 23; i >= 0; i--) if (!prog[i]) low = i;
        for (int i = 0; i < 24; i++) if (i <= low) msk[i] = 1'b0;
      end
      if ((prog & msk) != (dsrc & msk)) return 0;
    end
    return 1;
  endfunction

  task automatic chk(string req, bit [63:0] act, bit [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(bit [6:0] a, output bit [63:0] d);
    reg_rd_addr = a;
    #1;
    d = reg_rd_data;
  endtask

  // One clock: drive at the falling edge, update the model, land on the next falling edge.
  task automatic step(bit ev, bit [14:0] id, bit [23:0] dev, bit [19:0] pid, bit pv,
                      bit [15:0] gs, bit [19:0] ps, bit we, bit [6:0] wa, bit [63:0] wd);
    bit [NC:1] nx_ovf;
    bit irq_n;
    bit [14:0] code;
    evt_valid = ev; evt_id = id; evt_dev_id = dev; evt_pid = pid; evt_pid_valid = pv;
    evt_gscid = gs; evt_pscid = ps;
    reg_wr_en = we; reg_wr_addr = wa; reg_wr_data = wd;
    nx_ovf = m_ovf;
    irq_n = 0;
    for (int n = 0; n < NC; n++) begin
      bit touched = we && (wa == 7'(32 + n) || wa == 7'(64 + n));
      if (ev && !m_inh[n+1] && !touched && m_hit(m_sel[n], id, dev, pid, pv, gs, ps)) begin
        if (m_ctr[n] == '1) begin
          if (!m_ovf[n+1]) begin
            irq_n = 1;
            m_sel[n][63] = 1'b1;
          end
          nx_ovf[n+1] = 1'b1;
        end
        m_ctr[n] = m_ctr[n] + 1;
      end
    end
    if (we) begin
      if (wa == 7'd0) m_inh = wd[NC:1];
      for (int n = 0; n < NC; n++) begin
        if (wa == 7'(32 + n)) m_ctr[n] = wd;
        if (wa == 7'(64 + n)) begin
          code = wd[14:0];
          if (code == 0 || code >= NE) code = 0;
          if (!wd[63] && m_ovf[n+1]) nx_ovf[n+1] = 1'b0;
          m_sel[n] = {wd[63:15], code};
        end
      end
    end
    m_ovf = nx_ovf;
    m_irq = irq_n;
    @(posedge clk);
    @(negedge clk);
    evt_valid = 1'b0;
    reg_wr_en = 1'b0;
  endtask

  task automatic wr(bit [6:0] a, bit [63:0] d);
    step(0, 0, 0, 0, 0, 0, 0, 1, a, d);
  endtask

  task automatic ev(bit [14:0] id, bit [23:0] dev, bit [19:0] pid, bit pv,
                    bit [15:0] gs, bit [19:0] ps);
    step(1, id, dev, pid, pv, gs, ps, 0, 0, 0);
  endtask

  task automatic check_all(string req);
    bit [63:0] d;
    chk({req, " irq"}, 64'(pm_irq), 64'(m_irq));
    for (int n = 0; n < NC; n++) begin
      rd(7'(32 + n), d); chk({req, " ctr"}, d, m_ctr[n]);
      rd(7'(64 + n), d); chk({req, " sel"}, d, m_sel[n]);
    end
    rd(7'd1, d); chk({req, " summary"}, d, 64'({m_ovf, 1'b0}));
    rd(7'd0, d); chk({req, " inhibit"}, d, 64'({m_inh, 1'b0}));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit [63:0] d;
    m_inh = '0; m_ovf = '0; m_irq = 0;
    for (int n = 0; n < NC; n++) begin m_ctr[n] = '0; m_sel[n] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("reset R1 R10");

    // R3 code match, R9 legalising
    wr(7'd64, sel_word(15'd3, 0, 0, 0, 0, 0, 0));
    ev(15'd3, 0, 0, 0, 0, 0); ev(15'd4, 0, 0, 0, 0, 0);
    check_all("R3 code match");
    wr(7'd65, sel_word(15'd20, 0, 0, 0, 0, 0, 0));
    rd(7'd65, d); chk("R9 out-of-range code stored zero", d, 64'd0);
    ev(15'd0, 0, 0, 0, 0, 0);
    check_all("R3 zero code never matches");

    // R1/R2 inhibit of counter 0 via bit 1
    wr(7'd0, 64'h2);
    ev(15'd3, 0, 0, 0, 0, 0);
    check_all("R2 inhibited counter holds");
    wr(7'd0, 64'h0);
    wr(7'd1, 64'hFF);
    rd(7'd1, d); chk("R1 summary ignores writes", d, 64'd0);

    // R6 masked device filter: prog 0x0000B3 -> lowest zero at bit 2, ignore [2:0]
    wr(7'd65, sel_word(15'd5, 1, 0, 24'h0000B3, 0, 1, 0));
    ev(15'd5, 24'h0000B4, 0, 0, 0, 0);
    ev(15'd5, 24'h0000B8, 0, 0, 0, 0);
    check_all("R6 masked device range");
    wr(7'd65, sel_word(15'd5, 0, 0, 24'h0000B3, 0, 1, 0));
    ev(15'd5, 24'h0000B4, 0, 0, 0, 0); ev(15'd5, 24'h0000B3, 0, 0, 0, 0);
    check_all("R6 exact device");

    // R4 + R5 context selection and process filter
    wr(7'd66, sel_word(15'd7, 0, 20'h00123, 24'h000042, 1, 1, 1));
    ev(15'd7, 24'h000042, 20'h00123, 1, 16'h0041, 20'h00123);
    ev(15'd7, 24'h000000, 20'h00000, 1, 16'h0042, 20'h00123);
    ev(15'd7, 24'h000000, 20'h00000, 0, 16'h0042, 20'h00999);
    ev(15'd7, 24'h000000, 20'h00000, 1, 16'h0042, 20'h00999);
    check_all("R4 R5 guest context filters");

    // R7 wrap, fresh overflow, second wrap silent
    wr(7'd35, 64'hFFFF_FFFF_FFFF_FFFE);
    wr(7'd67, sel_word(15'd9, 0, 0, 0, 0, 0, 0));
    ev(15'd9, 0, 0, 0, 0, 0);
    ev(15'd9, 0, 0, 0, 0, 0);
    check_all("R7 wrap raises irq");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check_all("R7 irq lasts one cycle");
    wr(7'd35, 64'hFFFF_FFFF_FFFF_FFFF);
    ev(15'd9, 0, 0, 0, 0, 0);
    check_all("R7 repeat wrap no irq");

    // R8 clearing summary through selector write
    wr(7'd67, sel_word(15'd9, 0, 0, 0, 0, 0, 0));
    check_all("R8 summary cleared");

    // R11 write wins over event
    step(1, 15'd3, 0, 0, 0, 0, 0, 1, 7'd32, 64'd100);
    check_all("R11 write priority");

    // R10 unimplemented indices
    wr(7'(32 + NC), 64'h1234);
    wr(7'(64 + NC), 64'h5);
    rd(7'(32 + NC), d); chk("R10 absent counter reads zero", d, 0);
    rd(7'(64 + NC), d); chk("R10 absent selector reads zero", d, 0);
    rd(7'd100, d); chk("R10 unused address reads zero", d, 0);
    check_all("R10 state untouched");

    // Random phase with small code and identifier spaces
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 400; i++) begin
      int kind = $urandom_range(0, 9);
      bit [6:0] a;
      bit [63:0] w;
      if (kind == 0) begin
        a = 7'(64 + $urandom_range(0, NC));
        w = sel_word(15'($urandom_range(0, 6)), 1'($urandom), 20'($urandom_range(0, 3)),
                     24'($urandom_range(0, 15)), 1'($urandom), 1'($urandom), 1'($urandom));
        w[63] = 1'($urandom);
        step(1'($urandom), 15'($urandom_range(1, 5)), 24'($urandom_range(0, 15)),
             20'($urandom_range(0, 3)), 1'($urandom), 16'($urandom_range(0, 15)),
             20'($urandom_range(0, 3)), 1, a, w);
      end else if (kind == 1) begin
        a = 7'(32 + $urandom_range(0, NC - 1));
        w = 64'hFFFF_FFFF_FFFF_FFFF - 64'($urandom_range(0, 3));
        step(0, 0, 0, 0, 0, 0, 0, 1, a, w);
      end else if (kind == 2) begin
        step(0, 0, 0, 0, 0, 0, 0, 1, 7'd0, 64'($urandom));
      end else begin
        step(1, 15'($urandom_range(1, 5)), 24'($urandom_range(0, 15)),
             20'($urandom_range(0, 3)), 1'($urandom), 16'($urandom_range(0, 15)),
             20'($urandom_range(0, 3)), 0, 0, 0);
      end
      check_all("random R2 R3 R4 R5 R6 R7 R8 R9 R11");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule